// File: doc/BRIEF.md
# Calendar Counter with Deferred Register Commit

This block keeps wall-clock time and a calendar date. It advances once per one-second strobe. Time of day is held as seconds, minutes and hours. The date is held as day, month, a six-bit year offset counted from 1970, and a leap flag. Both words can be read at any moment as 32-bit values with fixed field positions.

Software loads new values through a single write port, where a select line picks the time word or the date word. A write does not change the visible value straight away. The value is latched in a holding slot and a per-word busy flag rises in the status word. On the next one-second strobe, every latched word replaces the live one and its busy flag drops. On a strobe that performs a commit, the counter does not advance.

Software is expected to poll the busy flags before it writes. Because the two words are read separately, software should also re-read a pair until two reads agree.

Top module: `cal_clock_top`

## Requirements
- R1: After reset, the time word reads 0x00000000, the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0) and the status word reads 0.
- R2: The time word carries seconds in bits [5:0], minutes in [13:8] and hours in [20:16]. The date word carries day in [4:0], month in [11:8], year offset in [21:16] and the leap flag in bit 22. Every other bit reads 0, and on a commit only these fields of the written value are kept.
- R3: The cycle after a write with select 0 (time), status bit 8 reads 1. The cycle after a write with select 1 (date), status bit 7 reads 1. All other status bits read 0.
- R4: While a write is pending, the visible time and date words do not change until the next strobe.
- R5: On the first strobe after a write, the latched value is committed exactly. It is visible, and its busy flag is clear, in the cycle after the strobe.
- R6: A strobe that commits either word does not advance the counter. A word with no pending write keeps its value on that strobe.
- R7: Without a commit, each strobe adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R8: The day wraps to 1 and the month advances after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except February.
- R9: February ends after day 29 when the leap flag is 1 and after day 28 when it is 0.
- R10: Month 12 wraps to 1 and the year offset advances, wrapping from 63 to 0. The leap flag then becomes 1 exactly when (year offset + 1970) is divisible by 4.
- R11: Cycles without a strobe never change the time or date word.
- R12: A second write to the same word before the strobe replaces the latched value. Only the last value is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 time word, 1 date word |
| wr_data_i | input | 32 | Write value |
| time_o | output | 32 | Current time word |
| date_o | output | 32 | Current date word |
| status_o | output | 32 | Busy flags: bit 8 time, bit 7 date |

## Verification
The embedded assertions check, on every cycle:
- a write raises its busy flag;
- a strobe clears an idle slot's busy flag;
- a commit reproduces the masked value that was written;
- a date-only commit leaves the time word untouched;
- nothing moves between strobes;
- the seconds and the December wrap-arounds land on their first values.

Month lengths, leap-year selection, the year-63 wrap and last-write-wins replacement depend on particular calendar states. Only the bench scenarios can show these, because they drive the counter to the last second of chosen days and compare against an independent calendar model.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int WORD_W   = 32;
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HOUR_W   = 5;
    localparam int DAY_W    = 5;
    localparam int MON_W    = 4;
    localparam int YEAR_W   = 6;

    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HOUR_LSB = 16;
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YEAR_LSB = 16;
    localparam int LEAP_BIT = 22;

    localparam int BUSY_DATE_BIT = 7;
    localparam int BUSY_TIME_BIT = 8;

    localparam int BASE_YEAR = 1970;
    localparam int LAST_SEC  = 59;
    localparam int LAST_MIN  = 59;
    localparam int LAST_HOUR = 23;
    localparam int LAST_MON  = 12;

    localparam int NUM_SLOTS = 2;
    localparam int SLOT_TIME = 0;
    localparam int SLOT_DATE = 1;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } hms_t;

    typedef struct packed {
        logic              leap;
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [DAY_W-1:0]  day;
    } ymd_t;

    function automatic hms_t word_to_hms(input logic [WORD_W-1:0] w);
        hms_t h;
        h.sec  = w[SEC_LSB  +: SEC_W];
        h.min  = w[MIN_LSB  +: MIN_W];
        h.hour = w[HOUR_LSB +: HOUR_W];
        return h;
    endfunction

    function automatic logic [WORD_W-1:0] hms_to_word(input hms_t h);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SEC_LSB  +: SEC_W]  = h.sec;
        w[MIN_LSB  +: MIN_W]  = h.min;
        w[HOUR_LSB +: HOUR_W] = h.hour;
        return w;
    endfunction

    function automatic ymd_t word_to_ymd(input logic [WORD_W-1:0] w);
        ymd_t d;
        d.day  = w[DAY_LSB  +: DAY_W];
        d.mon  = w[MON_LSB  +: MON_W];
        d.year = w[YEAR_LSB +: YEAR_W];
        d.leap = w[LEAP_BIT];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] ymd_to_word(input ymd_t d);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DAY_LSB  +: DAY_W]  = d.day;
        w[MON_LSB  +: MON_W]  = d.mon;
        w[YEAR_LSB +: YEAR_W] = d.year;
        w[LEAP_BIT]           = d.leap;
        return w;
    endfunction

    function automatic logic [DAY_W-1:0] month_last_day(input logic [MON_W-1:0] mon,
                                                         input logic leap);
        logic [DAY_W-1:0] n;
        case (mon)
            MON_W'(2):  n = leap ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4),
            MON_W'(6),
            MON_W'(9),
            MON_W'(11): n = DAY_W'(30);
            default:    n = DAY_W'(31);
        endcase
        return n;
    endfunction

    function automatic logic leap_of(input logic [YEAR_W-1:0] yr);
        int y;
        y = int'(yr) + BASE_YEAR;
        return logic'((y % 4) == 0);
    endfunction

endpackage

// File: rtl/cal_commit_slot.sv
module cal_commit_slot
#(
    parameter int W = 32
)
(
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         take_i,
    output logic         busy_o,
    output logic [W-1:0] data_o
);

    typedef struct packed {
        logic         busy;
        logic [W-1:0] data;
    } slot_t;

    slot_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.busy = 1'b0;
        end
        if (wr_i) begin
            st_d.busy = 1'b1;
            st_d.data = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign data_o = st_q.data;

    assert_busy_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> busy_o);

    assert_busy_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && take_i && !wr_i) |=> !busy_o);

    assert_last_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (data_o == $past(wr_data_i)));

endmodule

// File: rtl/cal_hms_counter.sv
module cal_hms_counter
    import cal_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    input  logic load_i,
    input  hms_t load_val_i,
    output hms_t hms_o,
    output logic day_carry_o
);

    hms_t hms_q, hms_d;
    logic carry;

    always_comb begin
        hms_d = hms_q;
        carry = 1'b0;
        if (load_i) begin
            hms_d = load_val_i;
        end else if (step_i) begin
            if (hms_q.sec >= SEC_W'(LAST_SEC)) begin
                hms_d.sec = '0;
                if (hms_q.min >= MIN_W'(LAST_MIN)) begin
                    hms_d.min = '0;
                    if (hms_q.hour >= HOUR_W'(LAST_HOUR)) begin
                        hms_d.hour = '0;
                        carry      = 1'b1;
                    end else begin
                        hms_d.hour = hms_q.hour + HOUR_W'(1);
                    end
                end else begin
                    hms_d.min = hms_q.min + MIN_W'(1);
                end
            end else begin
                hms_d.sec = hms_q.sec + SEC_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hms_q <= '0;
        end else begin
            hms_q <= hms_d;
        end
    end

    assign hms_o       = hms_q;
    assign day_carry_o = carry;

    assert_sec_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i && hms_q.sec == SEC_W'(LAST_SEC)) |=> (hms_q.sec == '0));

    assert_hms_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !load_i) |=> $stable(hms_q));

endmodule

// File: rtl/cal_ymd_counter.sv
module cal_ymd_counter
    import cal_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    input  logic load_i,
    input  ymd_t load_val_i,
    output ymd_t ymd_o
);

    localparam ymd_t YMD_RESET = '{leap: 1'b0, year: '0, mon: MON_W'(1), day: DAY_W'(1)};

    ymd_t ymd_q, ymd_d;
    logic [DAY_W-1:0]  last_day;
    logic [YEAR_W-1:0] next_year;

    always_comb begin
        ymd_d     = ymd_q;
        last_day  = month_last_day(ymd_q.mon, ymd_q.leap);
        next_year = ymd_q.year + YEAR_W'(1);
        if (load_i) begin
            ymd_d = load_val_i;
        end else if (step_i) begin
            if (ymd_q.day >= last_day) begin
                ymd_d.day = DAY_W'(1);
                if (ymd_q.mon >= MON_W'(LAST_MON)) begin
                    ymd_d.mon  = MON_W'(1);
                    ymd_d.year = next_year;
                    ymd_d.leap = leap_of(next_year);
                end else begin
                    ymd_d.mon = ymd_q.mon + MON_W'(1);
                end
            end else begin
                ymd_d.day = ymd_q.day + DAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ymd_q <= YMD_RESET;
        end else begin
            ymd_q <= ymd_d;
        end
    end

    assign ymd_o = ymd_q;

    assert_year_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i && ymd_q.mon == MON_W'(LAST_MON) && ymd_q.day == DAY_W'(31))
        |=> (ymd_q.mon == MON_W'(1) && ymd_q.day == DAY_W'(1)));

    assert_ymd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !load_i) |=> $stable(ymd_q));

endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
    import cal_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] time_o,
    output logic [WORD_W-1:0] date_o,
    output logic [WORD_W-1:0] status_o
);

    localparam logic [WORD_W-1:0] TIME_MASK = hms_to_word(hms_t'('1));
    localparam logic [WORD_W-1:0] DATE_MASK = ymd_to_word(ymd_t'('1));

    logic [NUM_SLOTS-1:0] busy;
    logic [WORD_W-1:0]    pend_data [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic slot_wr;
        assign slot_wr = wr_en_i && (wr_sel_i == (g == SLOT_DATE));
        cal_commit_slot #(.W(WORD_W)) u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_i      (slot_wr),
            .wr_data_i (wr_data_i),
            .take_i    (tick_i),
            .busy_o    (busy[g]),
            .data_o    (pend_data[g])
        );
    end

    logic step_sec;
    logic day_carry;
    hms_t hms;
    ymd_t ymd;

    assign step_sec = tick_i && !(|busy);

    cal_hms_counter u_hms (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .step_i      (step_sec),
        .load_i      (tick_i && busy[SLOT_TIME]),
        .load_val_i  (word_to_hms(pend_data[SLOT_TIME])),
        .hms_o       (hms),
        .day_carry_o (day_carry)
    );

    cal_ymd_counter u_ymd (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (day_carry),
        .load_i     (tick_i && busy[SLOT_DATE]),
        .load_val_i (word_to_ymd(pend_data[SLOT_DATE])),
        .ymd_o      (ymd)
    );

    always_comb begin
        status_o                = '0;
        status_o[BUSY_TIME_BIT] = busy[SLOT_TIME];
        status_o[BUSY_DATE_BIT] = busy[SLOT_DATE];
    end

    assign time_o = hms_to_word(hms);
    assign date_o = ymd_to_word(ymd);

    assert_commit_time_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && busy[SLOT_TIME]) |=> (time_o == ($past(pend_data[SLOT_TIME]) & TIME_MASK)));

    assert_commit_date_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && busy[SLOT_DATE]) |=> (date_o == ($past(pend_data[SLOT_DATE]) & DATE_MASK)));

    assert_commit_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && busy[SLOT_DATE] && !busy[SLOT_TIME]) |=> $stable(time_o));

    assert_no_tick_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> ($stable(time_o) && $stable(date_o)));

endmodule

// File: tb/tb_cal_clock_top.sv
`timescale 1ns/1ps
module tb_cal_clock_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] time_w, date_w, status_w;

    always #2.5 clk = ~clk;

    cal_clock_top dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .time_o    (time_w),
        .date_o    (date_w),
        .status_o  (status_w)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string       rq[$];
    logic [95:0] eq[$];
    event        sample_ev;

    // reference calendar model
    int m_sec, m_min, m_hour, m_day, m_mon, m_year, m_leap;
    bit p_t, p_d;
    logic [31:0] p_tw, p_dw;

    function automatic logic [31:0] exp_time();
        return (32'(m_hour) << 16) | (32'(m_min) << 8) | 32'(m_sec);
    endfunction

    function automatic logic [31:0] exp_date();
        return (32'(m_leap) << 22) | (32'(m_year) << 16) | (32'(m_mon) << 8) | 32'(m_day);
    endfunction

    function automatic logic [31:0] exp_status();
        return (32'(p_t) << 8) | (32'(p_d) << 7);
    endfunction

    function automatic logic [31:0] tw(input int h, input int mi, input int s);
        return (32'(h) << 16) | (32'(mi) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] dw(input int d, input int mo, input int y, input int lp);
        return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
    endfunction

    task automatic model_tick();
        int dim;
        if (p_t || p_d) begin
            if (p_t) begin
                m_sec = int'(p_tw[5:0]); m_min = int'(p_tw[13:8]); m_hour = int'(p_tw[20:16]);
            end
            if (p_d) begin
                m_day = int'(p_dw[4:0]); m_mon = int'(p_dw[11:8]);
                m_year = int'(p_dw[21:16]); m_leap = int'(p_dw[22]);
            end
            p_t = 1'b0; p_d = 1'b0;
        end else begin
            m_sec++;
            if (m_sec == 60) begin
                m_sec = 0; m_min++;
                if (m_min == 60) begin
                    m_min = 0; m_hour++;
                    if (m_hour == 24) begin
                        m_hour = 0;
                        if (m_mon == 2) dim = (m_leap != 0) ? 29 : 28;
                        else if (m_mon == 4 || m_mon == 6 || m_mon == 9 || m_mon == 11) dim = 30;
                        else dim = 31;
                        m_day++;
                        if (m_day > dim) begin
                            m_day = 1; m_mon++;
                            if (m_mon > 12) begin
                                m_mon = 1;
                                m_year = (m_year + 1) % 64;
                                m_leap = (((1970 + m_year) % 4) == 0) ? 1 : 0;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic do_write(input bit sel, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) begin p_d = 1'b1; p_dw = w; end
        else     begin p_t = 1'b1; p_tw = w; end
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
    endtask

    task automatic expect_now(input string r);
        rq.push_back(r);
        eq.push_back({exp_time(), exp_date(), exp_status()});
        -> sample_ev;
        #0.1;
    endtask

    task automatic set_both(input logic [31:0] t, input logic [31:0] d, input string r);
        do_write(1'b0, t);
        do_write(1'b1, d);
        expect_now("R3 both busy flags");
        do_tick();
        expect_now("R6 dual commit without increment");
        do_tick();
        expect_now(r);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(sample_ev);
            while (eq.size() > 0) begin
                logic [95:0] e;
                string r;
                e = eq.pop_front();
                r = rq.pop_front();
                checks++;
                if (time_w !== e[95:64] || date_w !== e[63:32] || status_w !== e[31:0]) begin
                    errors++;
                    $display("FAIL %s: time %h/%h date %h/%h status %h/%h (actual/expected)",
                             r, time_w, e[95:64], date_w, e[63:32], status_w, e[31:0]);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_mon = 1; m_year = 0; m_leap = 0;
        p_t = 1'b0; p_d = 1'b0; p_tw = '0; p_dw = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 reset state");

        // R2: stray bits outside the fields are dropped
        do_write(1'b0, 32'hFFE3_C0C0);
        expect_now("R3 time busy, R4 not yet applied");
        do_tick();
        expect_now("R2 time field masking");
        do_write(1'b1, 32'hFFC3_F3E5);
        do_tick();
        expect_now("R2 date field masking");

        // R5 / R4 / R6
        do_write(1'b0, tw(23, 59, 58));
        repeat (5) @(negedge clk);
        expect_now("R4 pending write not visible");
        do_tick();
        expect_now("R5 exact time commit");
        do_write(1'b1, dw(28, 2, 2, 1));
        expect_now("R3 date busy flag");
        do_tick();
        expect_now("R6 date commit holds time");

        // R7 / R9 leap February
        do_tick();
        expect_now("R7 second increment");
        do_tick();
        expect_now("R9 leap February 29");
        do_tick();
        expect_now("R7 plain increment");
        repeat (6) @(negedge clk);
        expect_now("R11 no change without strobe");

        set_both(tw(23, 59, 59), dw(28, 2, 3, 0), "R9 non-leap February to March");
        set_both(tw(23, 59, 59), dw(29, 2, 2, 1), "R9 leap February 29 to March");
        set_both(tw(23, 59, 59), dw(30, 4, 3, 0), "R8 April ends at 30");
        set_both(tw(23, 59, 59), dw(30, 1, 3, 0), "R8 January has day 31");
        do_tick(); do_tick();
        expect_now("R7 run of ticks");
        set_both(tw(23, 59, 59), dw(31, 1, 3, 0), "R8 January to February");
        set_both(tw(23, 59, 59), dw(31, 12, 5, 0), "R10 year rollover sets leap");
        set_both(tw(23, 59, 59), dw(31, 12, 63, 0), "R10 year offset wraps to 0");
        set_both(tw(10, 59, 59), dw(15, 6, 10, 0), "R7 minute and hour carry");

        // R12 last write wins
        do_write(1'b0, tw(1, 2, 3));
        do_write(1'b0, tw(4, 5, 6));
        expect_now("R12 busy after double write");
        do_tick();
        expect_now("R12 last written value committed");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule